// File: doc/BRIEF.md
# Serial EEPROM Read Responder

This block stands in for a 64-word, 16-bit serial EEPROM that host software reaches by toggling bits in a single control register. Four bits of that register carry the serial wires: chip select, clock, data into the memory and data out of it. Each time software writes the register with select high and the clock bit going from 0 to 1, the responder takes one serial step. It waits for a start bit, gathers a 2-bit command and a 6-bit word address, and then returns the addressed 16-bit word on the data-out bit, one bit per clock step.

Only the read command is served. The stored words come from a parameter holding the 48-bit station address. Three fixed word addresses return that address as byte pairs. Every other word reads as all ones. Any other command raises an error flag and drops the sequence.

Top module: `uwire_rom_responder`

## Requirements
- R1: After reset the register reads 0x12 and the error flag is low.
- R2: Register bits are: bit 0 data-in, bit 1 data-out, bit 2 clock, bit 3 select, bits 7:4 general storage. A write stores bits 0, 2, 3 and 7:4 as written. Bit 1 ignores write data and keeps its value, except on a data clock step.
- R3: The serial state advances only on a write where select is 1 and the clock bit goes from 0 to 1. Repeated writes with the clock held high do not advance it.
- R4: A write with select 0 returns the sequence to waiting for a start bit and forces bit 0 to 0. Bit 1 keeps its value.
- R5: While waiting, clock steps with data-in 0 are ignored. A clock step with data-in 1 is the start bit.
- R6: The 2 command bits that follow arrive MSB first. Only binary 10 (read) is accepted. Any other value sets the error flag and returns to waiting. A write with select 0 clears the flag.
- R7: After the command, 6 address bits arrive MSB first. On the step that takes the last address bit, bit 0 is forced to 0.
- R8: Word 0xC returns station bytes 1:0, word 0xB returns bytes 3:2, and word 0xA returns bytes 5:4. In each pair the higher-numbered byte is in bits 15:8. The station parameter holds byte 0 in bits 7:0.
- R9: Any other word address returns 0xFFFF.
- R10: The 16 data bits appear on bit 1 MSB first, one per clock step. After the 16th bit the sequence returns to waiting, and bit 1 holds the last bit sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| reg_q | output | 8 | Current register value |
| bad_cmd | output | 1 | Unsupported command seen since last deselect |

## Verification
Every serial effect belongs to the register write that causes it. The new register value, including a fresh data-out bit, and the error flag are therefore due one clock after the write strobe. The bench drives each write on a falling edge, holds it across one rising edge, and samples on the next falling edge. The result of every write is read before the next write is issued.

// File: rtl/uwire_rom_responder.sv
module uwire_rom_responder #(
  parameter int          REG_W        = 8,
  parameter int          ADDR_W       = 6,
  parameter int          DATA_W       = 16,
  parameter logic [7:0]  RST_VAL      = 8'h12,
  parameter logic [1:0]  CMD_READ     = 2'b10,
  parameter int          MAC_WORD0    = 12,
  parameter logic [47:0] STATION_ADDR = 48'h0A1B2C3D4E5F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] reg_q,
  output logic             bad_cmd
);
  localparam int DI = 0, DO = 1, CK = 2, CS = 3;
  localparam int CNT_W = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {S_WAIT, S_CMD, S_ADDR, S_DATA} st_t;
  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W-1:0] sr;

  wire sel  = wr_data[CS];
  wire din  = wr_data[DI];
  wire rise = wr_data[CK] & ~reg_q[CK];
  wire step = wr_en & sel & rise;
  wire [ADDR_W-1:0] addr_full = {sr[ADDR_W-2:0], din};

  function automatic logic [DATA_W-1:0] word_at(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] w;
    w = '1;
    for (int k = 0; k < 3; k++)
      if (a == ADDR_W'(MAC_WORD0 - k)) w = STATION_ADDR[16*k +: 16];
    return w;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q   <= RST_VAL;
      st      <= S_WAIT;
      cnt     <= '0;
      sr      <= '0;
      bad_cmd <= 1'b0;
    end else if (wr_en) begin
      reg_q <= {wr_data[REG_W-1:2], reg_q[DO], wr_data[DI]};
      if (!sel) begin
        st        <= S_WAIT;
        reg_q[DI] <= 1'b0;
        bad_cmd   <= 1'b0;
      end else if (rise) begin
        unique case (st)
          S_WAIT: if (din) begin
            st  <= S_CMD;
            cnt <= CNT_W'(1);
            sr  <= '0;
          end
          S_CMD: begin
            sr <= {sr[DATA_W-2:0], din};
            if (cnt == 0) begin
              if ({sr[0], din} == CMD_READ) begin
                st  <= S_ADDR;
                cnt <= CNT_W'(ADDR_W - 1);
              end else begin
                st      <= S_WAIT;
                bad_cmd <= 1'b1;
              end
            end else cnt <= cnt - 1'b1;
          end
          S_ADDR: begin
            if (cnt == 0) begin
              sr        <= word_at(addr_full);
              st        <= S_DATA;
              cnt       <= CNT_W'(DATA_W - 1);
              reg_q[DI] <= 1'b0;
            end else begin
              sr  <= {sr[DATA_W-2:0], din};
              cnt <= cnt - 1'b1;
            end
          end
          S_DATA: begin
            reg_q[DO] <= sr[DATA_W-1];
            sr        <= {sr[DATA_W-2:0], 1'b0};
            if (cnt == 0) st <= S_WAIT;
            else cnt <= cnt - 1'b1;
          end
          default: st <= S_WAIT;
        endcase
      end
    end
  end

  AST_DO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(step && st == S_DATA) |=> $stable(reg_q[DO])); // R2
  AST_NO_STEP_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (!sel || rise)) |=> $stable(st)); // R3
  AST_DESEL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel) |=> (st == S_WAIT && !reg_q[DI] && !bad_cmd)); // R4
  AST_ERR_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bad_cmd) |-> ($past(st) == S_CMD && st == S_WAIT)); // R6
  AST_DI_CLR_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_DATA) |-> !reg_q[DI]); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DATA_W - 1)); // R10
endmodule

// File: tb/uwire_rom_responder_tb_top.sv
module uwire_rom_responder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] reg_q;
  logic       bad_cmd;
  int checks = 0, fails = 0;
  bit done = 0;
  localparam logic [3:0] GP = 4'h5;

  always #5 clk = ~clk;

  uwire_rom_responder dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .reg_q(reg_q), .bad_cmd(bad_cmd));

  // {address[5:0], expected word[15:0]}
  localparam logic [21:0] VEC [6] = '{
    {6'h0C, 16'h4E5F}, {6'h0B, 16'h2C3D}, {6'h0A, 16'h0A1B},
    {6'h00, 16'hFFFF}, {6'h3F, 16'hFFFF}, {6'h0D, 16'hFFFF}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic step(input logic din);
    wr({GP, 1'b1, 1'b0, 1'b0, din});
    wr({GP, 1'b1, 1'b1, 1'b0, din});
  endtask

  task automatic send_hdr(input logic [5:0] a, input string req);
    step(1'b1); step(1'b1); step(1'b0);
    for (int i = 5; i >= 0; i--) step(a[i]);
    chk(req, {31'd0, reg_q[0]}, 32'd0);
  endtask

  task automatic get_word(output logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      step(1'b0);
      w[i] = reg_q[1];
    end
  endtask

  task automatic deselect();
    wr({GP, 4'b0000});
  endtask

  initial begin
    logic [15:0] w;
    repeat (3) @(negedge clk);
    chk("R1 reset reg", {24'd0, reg_q}, 32'h12);
    chk("R1 reset err", {31'd0, bad_cmd}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    wr(8'hAC);
    chk("R2 write store, DO kept", {24'd0, reg_q}, 32'hAE);
    wr(8'h51);
    chk("R4 deselect clears DI", {24'd0, reg_q}, 32'h52);

    for (int v = 0; v < 6; v++) begin
      deselect();
      send_hdr(VEC[v][21:16], "R7 DI cleared after address");
      get_word(w);
      chk((VEC[v][15:0] == 16'hFFFF) ? "R9 unmapped word" : "R8 station word",
          {16'd0, w}, {16'd0, VEC[v][15:0]});
    end

    deselect();
    step(1'b0); step(1'b0); step(1'b0);
    send_hdr(6'h0B, "R5 idle clocks ignored");
    get_word(w);
    chk("R5 read after idle zeros", {16'd0, w}, 32'h2C3D);

    deselect();
    step(1'b1);
    wr({GP, 4'b1101}); wr({GP, 4'b1100});
    step(1'b1); step(1'b0);
    for (int i = 5; i >= 0; i--) step(6'h0C >> i);
    get_word(w);
    chk("R3 held clock does not advance", {16'd0, w}, 32'h4E5F);

    chk("R10 DO holds last bit", {31'd0, reg_q[1]}, 32'd1);
    step(1'b0); step(1'b0);
    chk("R10 back to waiting, DO stable", {31'd0, reg_q[1]}, 32'd1);
    send_hdr(6'h0A, "R10 second read header");
    get_word(w);
    chk("R10 read without deselect", {16'd0, w}, 32'h0A1B);

    deselect();
    step(1'b1); step(1'b1); step(1'b1);
    chk("R6 bad command flag", {31'd0, bad_cmd}, 32'd1);
    send_hdr(6'h0C, "R6 header after error");
    get_word(w);
    chk("R6 return to waiting after error", {16'd0, w}, 32'h4E5F);
    deselect();
    chk("R6 flag cleared by deselect", {31'd0, bad_cmd}, 32'd0);

    step(1'b1); step(1'b0); step(1'b1);
    chk("R6 command 01 rejected", {31'd0, bad_cmd}, 32'd1);
    deselect();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule